// File: doc/BRIEF.md
# Load/Store Port Test Memory

This block is a small byte-addressed data memory that answers a processor's load/store port. The requester raises either a load or a store indicator. With it come an access size of 1, 2, 4 or 8 bytes, a privilege bit, and an address qualified by an address-valid bit. The block either rejects the request at once with a fault, or accepts the address with a one-cycle acknowledge. After that, a store takes one beat of write data marked by a store-valid strobe. A load returns its data with a one-cycle load-valid flag. Busy is high while an accepted operation is in flight.

Storage is little-endian: the byte at the lowest address sits in bits 7:0 of the data bus. Store data is taken from the low bytes of the bus. Load data comes back right-aligned and zero-extended. Two kinds of fault exist: a misaligned access and an illegal size code. Either fault is reported before any acknowledge, through a cause code and a fault-address register. A store flagged as a line clear writes zeros over a whole aligned line, whatever the size input says.

Once an operation completes or faults, the block does not start another until it has seen both request indicators low. This lets the requester hold its request for an extra cycle without causing a second access.

Top module: `lsmem_port`

## Requirements
- R1: After reset, busy_o, addr_ack_o, ld_vld_o and exc_happened_o are 0, exc_cause_o is 2'b00 and fault_addr_o is 0.
- R2: A request made while idle and armed, with addr_vld_i high, a legal size and an aligned address, raises addr_ack_o for exactly one cycle, in the cycle after the request is sampled. busy_o is high from that cycle until the operation completes.
- R3: A store writes exactly size_i bytes starting at addr_i, taking byte k from st_data_i[8k+7:8k], and leaves every other byte unchanged.
- R4: Store data is taken on the first cycle at or after the acknowledge cycle in which st_vld_i is high. For an ordinary store, busy_o is low in the next cycle.
- R5: A load raises ld_vld_o for exactly one cycle, the cycle after addr_ack_o. ld_data_o then holds the size_i bytes at addr_i, little-endian and zero-extended.
- R6: A legal-size, non-clearing request whose address is not a multiple of its size produces exc_happened_o=1 and exc_cause_o=2'b01 in the next cycle. In that cycle fault_addr_o equals the request address and addr_ack_o and busy_o stay low. Memory is not written.
- R7: A non-clearing request whose size_i is not 1, 2, 4 or 8 faults in the same way with exc_cause_o=2'b10.
- R8: After an operation completes or faults, a request held high does not start a new access. Only a request that begins after ld_req_i and st_req_i have both been seen low is taken.
- R9: exc_happened_o stays high until the next accepted request clears it. fault_addr_o keeps its value until the next fault.
- R10: A store with zero_i high is never faulted. It clears all bytes of the LINE_BYTES-aligned line holding addr_i, ignoring size_i, and keeps busy_o high for LINE_BYTES/8 cycles after the store-data cycle.
- R11: priv_i has no effect on acceptance, faults, stored data or loaded data.
- R12: No request is accepted while addr_vld_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req_i | input | 1 | Load indicator |
| st_req_i | input | 1 | Store indicator |
| size_i | input | 4 | Access size in bytes (1, 2, 4, 8) |
| priv_i | input | 1 | Privilege bit of the requester |
| zero_i | input | 1 | Store clears the whole line |
| addr_i | input | ADDR_W | Byte address |
| addr_vld_i | input | 1 | Address qualifier |
| st_data_i | input | 64 | Store data, low bytes used |
| st_vld_i | input | 1 | Store data strobe |
| busy_o | output | 1 | Accepted operation in flight |
| addr_ack_o | output | 1 | Address taken (one cycle) |
| ld_data_o | output | 64 | Load data, right-aligned |
| ld_vld_o | output | 1 | Load data valid (one cycle) |
| exc_happened_o | output | 1 | A fault was reported |
| exc_cause_o | output | 2 | 01 misaligned, 10 illegal size |
| fault_addr_o | output | ADDR_W | Address of the last faulting request |

## Verification
The bench builds the block with WORDS=64 and LINE_BYTES=32, which gives 512 bytes of storage in 16 lines of 4 words. At that size, random addresses fall on previously written bytes often enough that read-modify-write lane errors show up on later loads. Sixteen line clears then cover the whole array, so memory starts from a known state. The short line also lets every clear-busy window, and its boundary with the next access, be checked many times in a few thousand cycles.

// File: rtl/lsmem_pkg.sv
`timescale 1ns/1ps
// Package lsmem_pkg
// Shared state type, fault cause codes and size decode helpers for the
// load/store port memory. Assumes sizes are encoded as a byte count.
package lsmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACK  = 3'd1,
        ST_STW  = 3'd2,
        ST_ZERO = 3'd3,
        ST_LDV  = 3'd4
    } lsm_state_e;

    localparam logic [1:0] CAUSE_NONE  = 2'b00;
    localparam logic [1:0] CAUSE_ALIGN = 2'b01;
    localparam logic [1:0] CAUSE_SIZE  = 2'b10;

    // True when the size code is one of the four legal byte counts.
    function automatic logic size_legal(input logic [3:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
    endfunction

    // True when the low address bits are not a multiple of a legal size.
    function automatic logic off_misaligned(input logic [3:0] sz, input logic [2:0] off);
        logic bad;
        case (sz)
            4'd2:    bad = off[0];
            4'd4:    bad = |off[1:0];
            4'd8:    bad = |off;
            default: bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/lsmem_lanes.sv
`timescale 1ns/1ps
// Module lsmem_lanes
// Byte-lane steering for one 64-bit word: builds the write byte enables and
// shifted write data for a store, and right-aligns/zero-extends a read word
// for a load. Assumes size and offset are legal and aligned (checked upstream).
module lsmem_lanes #(
    parameter int DW = 64
) (
    input  logic [3:0]      size_i,
    input  logic [2:0]      off_i,
    input  logic [DW-1:0]   st_data_i,
    input  logic [DW-1:0]   rword_i,
    output logic [DW/8-1:0] be_o,
    output logic [DW-1:0]   wdata_o,
    output logic [DW-1:0]   ld_data_o
);
    localparam int LANES = DW / 8;

    logic [4:0]    lo_b;
    logic [4:0]    hi_b;
    logic [DW-1:0] rshift;

    // Lane window and shifted data paths.
    always_comb begin
        lo_b    = {2'b00, off_i};
        hi_b    = lo_b + {1'b0, size_i};
        wdata_o = st_data_i << {off_i, 3'b000};
        rshift  = rword_i >> {off_i, 3'b000};
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Enable lane i when it lies inside the accessed byte window.
        assign be_o[i] = (5'(i) >= lo_b) && (5'(i) < hi_b);
        // Keep lane i of the aligned read only when it lies inside the size.
        assign ld_data_o[8*i +: 8] = (5'(i) < {1'b0, size_i}) ? rshift[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/lsmem_bank.sv
`timescale 1ns/1ps
// Module lsmem_bank
// Word-wide storage split into one byte array per lane, with a byte-enabled
// write port and a registered read port. Contents are not reset.
module lsmem_bank #(
    parameter int WORDS = 512,
    parameter int DW    = 64,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [DW/8-1:0] be_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            re_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [DW-1:0]   rdata_o
);
    localparam int LANES = DW / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] arr [WORDS];

        // Write byte lane i when enabled.
        always_ff @(posedge clk) begin
            if (we_i && be_i[i]) begin
                arr[waddr_i] <= wdata_i[8*i +: 8];
            end
        end

        // Register the read of byte lane i.
        always_ff @(posedge clk) begin
            if (re_i) begin
                rdata_o[8*i +: 8] <= arr[raddr_i];
            end
        end
    end

endmodule

// File: rtl/lsmem_ctrl.sv
`timescale 1ns/1ps
// Module lsmem_ctrl
// Request sequencer: arms on an idle bus, checks size and alignment, raises
// faults before any acknowledge, acknowledges good requests, then waits for
// store data, walks a line clear, or issues the read for a load.
// Assumes the requester obeys busy and holds its request until done.
module lsmem_ctrl
    import lsmem_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req_i,
    input  logic              st_req_i,
    input  logic [3:0]        size_i,
    input  logic              zero_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic              st_vld_i,
    output logic              busy_o,
    output logic              addr_ack_o,
    output logic              ld_vld_o,
    output logic [1:0]        exc_cause_o,
    output logic [ADDR_W-1:0] fault_addr_o,
    output logic [3:0]        cap_size_o,
    output logic [2:0]        cap_off_o,
    output logic              mem_we_o,
    output logic              zero_fill_o,
    output logic [ADDR_W-4:0] mem_waddr_o,
    output logic              mem_re_o,
    output logic [ADDR_W-4:0] mem_raddr_o
);
    localparam int LINE_AW = $clog2(LINE_BYTES);
    localparam int LW_AW   = LINE_AW - 3;

    lsm_state_e        state;
    logic              armed;
    logic [ADDR_W-1:0] cap_addr;
    logic [3:0]        cap_size;
    logic              cap_st;
    logic              cap_zero;
    logic [LW_AW-1:0]  zcnt;
    logic              take;
    logic              clr_req;
    logic              bad_size;
    logic              bad_off;
    logic              commit;

    // Decode the incoming request and the store-data commit point.
    always_comb begin
        take     = (state == ST_IDLE) && armed && addr_vld_i && (ld_req_i || st_req_i);
        clr_req  = st_req_i && zero_i;
        bad_size = !size_legal(size_i);
        bad_off  = off_misaligned(size_i, addr_i[2:0]);
        commit   = ((state == ST_ACK) || (state == ST_STW)) && cap_st && st_vld_i;
    end

    // Sequencer state, capture registers and fault record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            armed        <= 1'b1;
            cap_addr     <= '0;
            cap_size     <= 4'd0;
            cap_st       <= 1'b0;
            cap_zero     <= 1'b0;
            zcnt         <= '0;
            exc_cause_o  <= CAUSE_NONE;
            fault_addr_o <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        armed <= 1'b0;
                        if (!clr_req && bad_size) begin
                            exc_cause_o  <= CAUSE_SIZE;
                            fault_addr_o <= addr_i;
                        end else if (!clr_req && bad_off) begin
                            exc_cause_o  <= CAUSE_ALIGN;
                            fault_addr_o <= addr_i;
                        end else begin
                            exc_cause_o <= CAUSE_NONE;
                            cap_addr    <= addr_i;
                            cap_size    <= size_i;
                            cap_st      <= st_req_i;
                            cap_zero    <= clr_req;
                            state       <= ST_ACK;
                        end
                    end else if (!ld_req_i && !st_req_i) begin
                        armed <= 1'b1;
                    end
                end
                ST_ACK, ST_STW: begin
                    if (!cap_st) begin
                        state <= ST_LDV;
                    end else if (commit) begin
                        zcnt  <= '0;
                        state <= cap_zero ? ST_ZERO : ST_IDLE;
                    end else begin
                        state <= ST_STW;
                    end
                end
                ST_ZERO: begin
                    zcnt <= zcnt + 1'b1;
                    if (&zcnt) begin
                        state <= ST_IDLE;
                    end
                end
                ST_LDV: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Port handshake outputs and memory port controls.
    always_comb begin
        busy_o      = (state != ST_IDLE);
        addr_ack_o  = (state == ST_ACK);
        ld_vld_o    = (state == ST_LDV);
        zero_fill_o = (state == ST_ZERO);
        mem_we_o    = (commit && !cap_zero) || zero_fill_o;
        mem_waddr_o = zero_fill_o ? {cap_addr[ADDR_W-1:LINE_AW], zcnt} : cap_addr[ADDR_W-1:3];
        mem_re_o    = (state == ST_ACK) && !cap_st;
        mem_raddr_o = cap_addr[ADDR_W-1:3];
        cap_size_o  = cap_size;
        cap_off_o   = cap_addr[2:0];
    end

endmodule

// File: rtl/lsmem_port.sv
`timescale 1ns/1ps
// Module lsmem_port
// Top of the load/store port test memory: sequencer, lane steering and a
// byte-lane storage bank. Little-endian, 64-bit words, WORDS deep.
// Assumes LINE_BYTES is a power of two between 16 and WORDS*8.
module lsmem_port
    import lsmem_pkg::*;
#(
    parameter int WORDS      = 512,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = $clog2(WORDS) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req_i,
    input  logic              st_req_i,
    input  logic [3:0]        size_i,
    input  logic              priv_i,
    input  logic              zero_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic [63:0]       st_data_i,
    input  logic              st_vld_i,
    output logic              busy_o,
    output logic              addr_ack_o,
    output logic [63:0]       ld_data_o,
    output logic              ld_vld_o,
    output logic              exc_happened_o,
    output logic [1:0]        exc_cause_o,
    output logic [ADDR_W-1:0] fault_addr_o
);
    localparam int DW    = 64;
    localparam int LANES = DW / 8;
    localparam int WAW   = ADDR_W - 3;

    logic [3:0]       cap_size;
    logic [2:0]       cap_off;
    logic             mem_we;
    logic             zero_fill;
    logic [WAW-1:0]   mem_waddr;
    logic             mem_re;
    logic [WAW-1:0]   mem_raddr;
    logic [LANES-1:0] lane_be;
    logic [DW-1:0]    lane_wdata;
    logic [LANES-1:0] bank_be;
    logic [DW-1:0]    bank_wdata;
    logic [DW-1:0]    bank_rdata;

    lsmem_ctrl #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_req_i     (ld_req_i),
        .st_req_i     (st_req_i),
        .size_i       (size_i),
        .zero_i       (zero_i),
        .addr_i       (addr_i),
        .addr_vld_i   (addr_vld_i),
        .st_vld_i     (st_vld_i),
        .busy_o       (busy_o),
        .addr_ack_o   (addr_ack_o),
        .ld_vld_o     (ld_vld_o),
        .exc_cause_o  (exc_cause_o),
        .fault_addr_o (fault_addr_o),
        .cap_size_o   (cap_size),
        .cap_off_o    (cap_off),
        .mem_we_o     (mem_we),
        .zero_fill_o  (zero_fill),
        .mem_waddr_o  (mem_waddr),
        .mem_re_o     (mem_re),
        .mem_raddr_o  (mem_raddr)
    );

    lsmem_lanes #(
        .DW (DW)
    ) u_lanes (
        .size_i    (cap_size),
        .off_i     (cap_off),
        .st_data_i (st_data_i),
        .rword_i   (bank_rdata),
        .be_o      (lane_be),
        .wdata_o   (lane_wdata),
        .ld_data_o (ld_data_o)
    );

    // Line clears write zeros on every lane; ordinary stores use the lanes.
    always_comb begin
        bank_be    = zero_fill ? {LANES{1'b1}} : lane_be;
        bank_wdata = zero_fill ? '0 : lane_wdata;
    end

    lsmem_bank #(
        .WORDS (WORDS),
        .DW    (DW),
        .AW    (WAW)
    ) u_bank (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .be_i    (bank_be),
        .wdata_i (bank_wdata),
        .re_i    (mem_re),
        .raddr_i (mem_raddr),
        .rdata_o (bank_rdata)
    );

    // Fault flag follows the stored cause.
    assign exc_happened_o = (exc_cause_o != CAUSE_NONE);

endmodule

// File: rtl/lsmem_port_chk.sv
`timescale 1ns/1ps
// Module lsmem_port_chk
// Port-level protocol checker for lsmem_port, attached by bind.
module lsmem_port_chk
    import lsmem_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_req_i,
    input logic              st_req_i,
    input logic [3:0]        size_i,
    input logic              priv_i,
    input logic              zero_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              addr_vld_i,
    input logic [63:0]       st_data_i,
    input logic              st_vld_i,
    input logic              busy_o,
    input logic              addr_ack_o,
    input logic [63:0]       ld_data_o,
    input logic              ld_vld_o,
    input logic              exc_happened_o,
    input logic [1:0]        exc_cause_o,
    input logic [ADDR_W-1:0] fault_addr_o
);
    p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_o |=> !addr_ack_o);

    p_ack_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_o |-> busy_o);

    p_ldv_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld_o |-> $past(addr_ack_o));

    p_ack_ldv_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_ack_o, ld_vld_o}));

    p_fault_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_happened_o) |-> (!addr_ack_o && !busy_o));

    p_fault_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_happened_o) |-> (fault_addr_o == $past(addr_i)));

    p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_happened_o) |-> (exc_cause_o == CAUSE_ALIGN || exc_cause_o == CAUSE_SIZE));

    p_fault_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr_o) |-> exc_happened_o);

    p_ack_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_ack_o) |-> ($past(addr_vld_i) && $past(ld_req_i || st_req_i)));

    p_priv_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_ack_o) && $past(priv_i)) |-> !exc_happened_o);

endmodule

bind lsmem_port lsmem_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lsmem_port_tb_top.sv
`timescale 1ns/1ps
// Bench for lsmem_port: directed corners plus seeded random traffic,
// checked against a byte-array model.
module lsmem_port_tb_top;
    localparam int WORDS      = 64;
    localparam int LINE_BYTES = 32;
    localparam int ADDR_W     = $clog2(WORDS) + 3;
    localparam int NBYTES     = WORDS * 8;
    localparam int LWORDS     = LINE_BYTES / 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ld_req_i, st_req_i, priv_i, zero_i, addr_vld_i, st_vld_i;
    logic [3:0]        size_i;
    logic [ADDR_W-1:0] addr_i;
    logic [63:0]       st_data_i;
    logic              busy_o, addr_ack_o, ld_vld_o, exc_happened_o;
    logic [63:0]       ld_data_o;
    logic [1:0]        exc_cause_o;
    logic [ADDR_W-1:0] fault_addr_o;

    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;
    logic [7:0] model [NBYTES];

    lsmem_port #(.WORDS(WORDS), .LINE_BYTES(LINE_BYTES)) dut_i (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input logic [3:0] s);
        return (s == 1) || (s == 2) || (s == 4) || (s == 8);
    endfunction

    function automatic logic [63:0] exp_load(input int a, input int s);
        logic [63:0] v = '0;
        for (int k = 0; k < s; k++) v[8*k +: 8] = model[a + k];
        return v;
    endfunction

    task automatic drop_req();
        ld_req_i = 0; st_req_i = 0; addr_vld_i = 0; zero_i = 0; st_vld_i = 0;
        @(negedge clk);
    endtask

    // Fault path: one-cycle report, hold one more cycle, then release.
    task automatic fault_path(input int a, input logic [3:0] s, input logic [1:0] cause, input logic [ADDR_W-1:0] prev_fa);
        chk(exc_happened_o == 1, "R6 fault flag", exc_happened_o, 1);
        chk(exc_cause_o == cause, (cause == 2'b01) ? "R6 cause" : "R7 cause", exc_cause_o, cause);
        chk(fault_addr_o == a[ADDR_W-1:0], "R6 fault addr", fault_addr_o, a);
        chk(!addr_ack_o && !busy_o, "R6 no ack/busy", {addr_ack_o, busy_o}, 0);
        @(negedge clk);
        chk(!addr_ack_o && !busy_o, "R8 held after fault", {addr_ack_o, busy_o}, 0);
        drop_req();
        chk(fault_addr_o == a[ADDR_W-1:0] && prev_fa == prev_fa, "R9 fault addr held", fault_addr_o, a);
    endtask

    task automatic do_store(input int a, input logic [3:0] s, input logic [63:0] d, input bit z, input bit p, input int gap);
        logic [ADDR_W-1:0] pfa = fault_addr_o;
        int n = 0;
        st_req_i = 1; ld_req_i = 0; size_i = s; addr_i = a[ADDR_W-1:0];
        addr_vld_i = 1; zero_i = z; priv_i = p;
        @(negedge clk);
        if (!z && !legal(s)) begin fault_path(a, s, 2'b10, pfa); return; end
        if (!z && (a % s) != 0) begin fault_path(a, s, 2'b01, pfa); return; end
        chk(addr_ack_o && busy_o, "R2 store ack", {addr_ack_o, busy_o}, 2'b11);
        chk(!exc_happened_o, "R9 exc cleared", exc_happened_o, 0);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(!addr_ack_o && busy_o, "R4 waiting for data", {addr_ack_o, busy_o}, 2'b01);
        end
        st_data_i = d; st_vld_i = 1;
        @(negedge clk);
        st_vld_i = 0;
        while (busy_o && n < 40) begin @(negedge clk); n++; end
        chk(n == (z ? LWORDS : 0), z ? "R10 clear busy length" : "R4 busy drops", n, z ? LWORDS : 0);
        if (z) begin
            int base = a - (a % LINE_BYTES);
            for (int k = 0; k < LINE_BYTES; k++) model[base + k] = 8'h00;
        end else begin
            for (int k = 0; k < s; k++) model[a + k] = d[8*k +: 8];
        end
        @(negedge clk);
        chk(!addr_ack_o && !busy_o, "R8 held after store", {addr_ack_o, busy_o}, 0);
        drop_req();
    endtask

    task automatic do_load(input int a, input logic [3:0] s, input bit p, input string tag);
        logic [ADDR_W-1:0] pfa = fault_addr_o;
        logic [63:0] e;
        ld_req_i = 1; st_req_i = 0; size_i = s; addr_i = a[ADDR_W-1:0];
        addr_vld_i = 1; zero_i = 0; priv_i = p;
        @(negedge clk);
        if (!legal(s)) begin fault_path(a, s, 2'b10, pfa); return; end
        if ((a % s) != 0) begin fault_path(a, s, 2'b01, pfa); return; end
        chk(addr_ack_o && !ld_vld_o, "R2 load ack", {addr_ack_o, ld_vld_o}, 2'b10);
        @(negedge clk);
        e = exp_load(a, s);
        chk(ld_vld_o && !addr_ack_o, "R5 load valid", {ld_vld_o, addr_ack_o}, 2'b10);
        chk(ld_data_o == e, tag, ld_data_o, e);
        @(negedge clk);
        chk(!ld_vld_o && !busy_o && !addr_ack_o, "R8 held after load", {ld_vld_o, busy_o, addr_ack_o}, 0);
        drop_req();
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; ld_req_i = 0; st_req_i = 0; priv_i = 0; zero_i = 0;
        addr_vld_i = 0; st_vld_i = 0; size_i = 0; addr_i = '0; st_data_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !addr_ack_o && !ld_vld_o && !exc_happened_o, "R1 reset outputs",
            {busy_o, addr_ack_o, ld_vld_o, exc_happened_o}, 0);
        chk(exc_cause_o == 0 && fault_addr_o == 0, "R1 reset fault record", {exc_cause_o, fault_addr_o}, 0);

        // R10: clear every line with odd offsets and ignored sizes.
        for (int l = 0; l < NBYTES / LINE_BYTES; l++) begin
            logic [3:0] zs = (l % 3 == 0) ? 4'd3 : ((l % 3 == 1) ? 4'd8 : 4'd0);
            do_store(l * LINE_BYTES + ($urandom % LINE_BYTES), zs, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, l % 2);
        end
        do_load(0, 8, 0, "R10 cleared word 0");
        do_load(NBYTES - 8, 8, 0, "R10 cleared last word");

        // R3 / R5: two half-words then one word across them.
        do_store(16, 2, 64'h0000_0000_0000_BEEF, 0, 0, 0);
        do_store(18, 2, 64'h0000_0000_0000_CAFE, 0, 0, 2);
        do_load(16, 4, 0, "R3 little-endian word");
        do_load(16, 8, 0, "R3 neighbours untouched");

        // R6: misaligned store must not write.
        do_store(41, 4, 64'h1111_2222_3333_4444, 0, 0, 0);
        do_load(40, 8, 0, "R6 no write on fault");
        // R9: accepted load clears the flag, fault address retained.
        chk(fault_addr_o == 41, "R9 fault addr kept", fault_addr_o, 41);
        // R7: illegal size on a load.
        do_load(24, 4'd6, 0, "R7 unused");
        // R11: privileged store read back unprivileged.
        do_store(64, 8, 64'h0123_4567_89AB_CDEF, 0, 1, 1);
        do_load(64, 8, 0, "R11 priv has no effect");

        // R12: no acceptance without address valid.
        ld_req_i = 1; addr_vld_i = 0; size_i = 4; addr_i = '0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(!addr_ack_o && !busy_o, "R12 addr valid low", {addr_ack_o, busy_o}, 0);
        end
        drop_req();

        // Random traffic.
        for (int i = 0; i < 400; i++) begin
            int         r  = $urandom % 16;
            logic [3:0] s  = 4'd1 << ($urandom % 4);
            int         a  = $urandom % NBYTES;
            bit         p  = $urandom % 2;
            if (r == 0) s = 4'($urandom % 16);
            if (legal(s) && ($urandom % 8) != 0) a = a - (a % s);
            if (legal(s) && a + s > NBYTES) a = NBYTES - s;
            if ($urandom % 2) do_store(a, s, {$urandom, $urandom}, (r == 1), p, $urandom % 3);
            else              do_load(a, s, p, "R5 random load data");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule